// File: doc/BRIEF.md
# Two-Level 32-bit Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking the classic two-level 32-bit page table held in memory. A request carries the virtual address, whether the access is a write, and whether it comes from user privilege. The walker reads the directory entry through a simple request/acknowledge memory port. It then either stops there on a large page or reads a table entry for a small page. It reports one result per walk.

Two page sizes are supported. Small pages are 4 KB. Large pages are 4 MB and are only recognised when the page-size extension input is set. A large-page entry also supplies eight extra physical address bits, so the physical address output is 40 bits wide. The walker returns the combined user and write rights of the entries it used, or a fault with a small code. It keeps the accessed and dirty bits in memory up to date by writing entries back through the same port.

Permission decisions, caching of translations and the wider entry formats belong to neighbouring logic.

Top module: `pt32_walker`

## Requirements
- R1: The directory entry address is `{root[31:12], 12'h000} + 4*va[31:22]`, ANDed with `a20_mask`.
- R2: The table entry address is `{pde[31:12], 12'h000} + 4*va[21:12]`, ANDed with `a20_mask`.
- R3: Entry bit 7 set in a present directory entry selects a 4 MB page only while `pse_en` is 1. While `pse_en` is 0 the bit has no effect and the table entry is read.
- R4: The physical address is `{pde[20:13], pde[31:22], va[21:0]}` for a 4 MB page (`big_page`=1). It is `{8'h00, pte[31:12], va[11:0]}` for a 4 KB page (`big_page`=0).
- R5: On a 4 MB page, directory bit 21 set gives a fault with `fault_code[3]` (reserved) and `fault_code[0]` (protection) both set. A 4 KB walk never raises a reserved fault, whatever the other entry bits hold.
- R6: An entry with bit 0 (present) clear, at either level, ends the walk with `fault`=1 and `fault_code[0]`=0, with no write-back. In every fault, `fault_code[1]` equals the write flag and `fault_code[2]` equals the user flag of the request.
- R7: On the 4 KB path, a directory entry with bit 5 (accessed) clear is written back with bit 5 set, before the table entry is read. On the 4 MB path the directory entry gets only the leaf update.
- R8: `rights_user` is the AND of the user bits (bit 2), and `rights_write` the AND of the write bits (bit 1), of the entries used.
- R9: The leaf entry gets exactly one write-back when bit 5 is clear, or when the access is a write and bit 6 (dirty) is clear. That write-back sets bit 5, and also bit 6 on a write. Otherwise the leaf is not written.
- R10: A memory request holds its address, direction and data until `mem_ack`. `result_valid` is a one-cycle pulse. `busy` is high from the cycle after acceptance until the result. No memory request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (accepted when not busy) |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| cfg_root | input | 32 | Directory base register |
| cfg_pse | input | 1 | Page-size extension enable |
| cfg_a20_mask | input | 32 | Mask applied to entry addresses |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| result_valid | output | 1 | Result pulse |
| fault | output | 1 | Walk faulted |
| fault_code | output | 4 | {reserved, user, write, protection} |
| phys_addr | output | 40 | Translated physical address |
| big_page | output | 1 | 1 for 4 MB page, 0 for 4 KB |
| rights_user | output | 1 | Combined user right |
| rights_write | output | 1 | Combined write right |

## Verification
The bench logs every memory transaction of each walk. It compares the order, addresses and write data against a model, so a missing or extra write-back, or a directory write-back issued after the table read, shows up as a sequence mismatch. Directed cases target the page-size bit with extension off, which a faulty walker would turn into a large page. They also cover bit 21 on a large page versus a small page, where a faulty walker misses or invents a reserved fault, and a mask that clears address bit 20, where a walker that skips the mask fetches the wrong entry. Further cases check the extended frame bits, which a walker could drop from the top of the physical address, and the rights AND, where taking only the leaf's bits would report write permission wrongly.

// File: rtl/pt32_walker.sv
module pt32_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] cfg_root,
  input  logic        cfg_pse,
  input  logic [31:0] cfg_a20_mask,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        result_valid,
  output logic        fault,
  output logic [3:0]  fault_code,
  output logic [39:0] phys_addr,
  output logic        big_page,
  output logic        rights_user,
  output logic        rights_write
);
  localparam int B_P   = 0;
  localparam int B_RW  = 1;
  localparam int B_US  = 2;
  localparam int B_ACC = 5;
  localparam int B_DRT = 6;
  localparam int B_PS  = 7;
  localparam int B_RSV = 21;

  typedef enum logic [2:0] {S_IDLE, S_RD_DIR, S_WB_DIR, S_RD_TBL, S_WB_LEAF, S_DONE} st_t;

  st_t         st;
  logic [31:0] va, dir_addr, leaf_addr, pde, leaf;
  logic        wr, usr;
  logic [31:0] tbl_addr, leaf_set;

  assign tbl_addr = ({pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00}) & cfg_a20_mask;
  assign leaf_set = leaf | (32'h1 << B_ACC) | (wr ? (32'h1 << B_DRT) : 32'h0);

  function automatic logic needs_wb(input logic [31:0] e, input logic w);
    return !e[B_ACC] || (w && !e[B_DRT]);
  endfunction

  assign busy         = (st != S_IDLE);
  assign result_valid = (st == S_DONE);
  assign mem_req      = (st == S_RD_DIR) || (st == S_WB_DIR) || (st == S_RD_TBL) || (st == S_WB_LEAF);
  assign mem_we       = (st == S_WB_DIR) || (st == S_WB_LEAF);
  assign mem_addr     = (st == S_RD_TBL) ? tbl_addr : (st == S_WB_LEAF) ? leaf_addr : dir_addr;
  assign mem_wdata    = (st == S_WB_DIR) ? (pde | (32'h1 << B_ACC)) : leaf_set;
  assign phys_addr    = big_page ? {leaf[20:13], leaf[31:22], va[21:0]}
                                 : {8'h00, leaf[31:12], va[11:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va <= '0; dir_addr <= '0; leaf_addr <= '0; pde <= '0; leaf <= '0;
      wr <= 1'b0; usr <= 1'b0;
      fault <= 1'b0; fault_code <= '0; big_page <= 1'b0;
      rights_user <= 1'b0; rights_write <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va       <= req_vaddr;
          wr       <= req_write;
          usr      <= req_user;
          dir_addr <= ({cfg_root[31:12], 12'h000} + {20'h0, req_vaddr[31:22], 2'b00}) & cfg_a20_mask;
          fault    <= 1'b0;
          fault_code <= '0;
          big_page <= 1'b0;
          st       <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_ack) begin
          pde <= mem_rdata;
          rights_user  <= mem_rdata[B_US];
          rights_write <= mem_rdata[B_RW];
          if (!mem_rdata[B_P]) begin
            fault <= 1'b1;
            fault_code <= {1'b0, usr, wr, 1'b0};
            st <= S_DONE;
          end else if (mem_rdata[B_PS] && cfg_pse) begin
            big_page  <= 1'b1;
            leaf      <= mem_rdata;
            leaf_addr <= dir_addr;
            if (mem_rdata[B_RSV]) begin
              fault <= 1'b1;
              fault_code <= {1'b1, usr, wr, 1'b1};
              st <= S_DONE;
            end else begin
              st <= needs_wb(mem_rdata, wr) ? S_WB_LEAF : S_DONE;
            end
          end else begin
            st <= mem_rdata[B_ACC] ? S_RD_TBL : S_WB_DIR;
          end
        end
        S_WB_DIR: if (mem_ack) begin
          pde <= pde | (32'h1 << B_ACC);
          st  <= S_RD_TBL;
        end
        S_RD_TBL: if (mem_ack) begin
          if (!mem_rdata[B_P]) begin
            fault <= 1'b1;
            fault_code <= {1'b0, usr, wr, 1'b0};
            st <= S_DONE;
          end else begin
            leaf         <= mem_rdata;
            leaf_addr    <= tbl_addr;
            rights_user  <= rights_user & mem_rdata[B_US];
            rights_write <= rights_write & mem_rdata[B_RW];
            st <= needs_wb(mem_rdata, wr) ? S_WB_LEAF : S_DONE;
          end
        end
        S_WB_LEAF: if (mem_ack) begin
          leaf <= leaf_set;
          st   <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r5_rsvd_big: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && fault_code[3] |-> big_page && fault_code[0] && fault);
  a_r6_np_noprot: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && fault && !fault_code[3] |-> !fault_code[0]);
  a_r9_wb_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[B_ACC]);
  a_r7_dirwb_small: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB_DIR) |-> !big_page);
endmodule

// File: tb/pt32_walker_tb.sv
module pt32_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] cfg_root = '0;
  logic        cfg_pse = 1'b0;
  logic [31:0] cfg_a20_mask = 32'hFFFF_FFFF;
  logic        busy, mem_req, mem_we, mem_ack, result_valid, fault, big_page, rights_user, rights_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  fault_code;
  logic [39:0] phys_addr;

  always #5 clk = ~clk;

  pt32_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .cfg_root(cfg_root), .cfg_pse(cfg_pse),
    .cfg_a20_mask(cfg_a20_mask), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .result_valid(result_valid), .fault(fault), .fault_code(fault_code), .phys_addr(phys_addr),
    .big_page(big_page), .rights_user(rights_user), .rights_write(rights_write));

  logic [31:0] mem [logic [31:0]];
  logic [31:0] lg_addr [8];
  logic [31:0] lg_wd [8];
  logic        lg_we [8];
  int          lg_n;
  int          n_chk = 0;
  int          n_fail = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return (a * 32'h9E37_79B1) ^ (a >> 9) ^ 32'h5A3C_1E27;
  endfunction

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    lg_n = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= rd(mem_addr);
        if (lg_n < 8) begin
          lg_addr[lg_n] = mem_addr;
          lg_we[lg_n] = mem_we;
          lg_wd[lg_n] = mem_we ? mem_wdata : 32'h0;
          lg_n = lg_n + 1;
        end
      end
      if (mem_req && mem_ack && mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_a(input logic [31:0] root, input logic [31:0] va, input logic [31:0] m);
    return ({root[31:12], 12'h000} + {20'h0, va[31:22], 2'b00}) & m;
  endfunction
  function automatic logic [31:0] tbl_a(input logic [31:0] pde, input logic [31:0] va, input logic [31:0] m);
    return ({pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00}) & m;
  endfunction

  logic        e_fault, e_big, e_u, e_w;
  logic [3:0]  e_code;
  logic [39:0] e_phys;
  logic [31:0] e_addr [8];
  logic [31:0] e_wd [8];
  logic        e_we [8];
  int          e_n;

  task automatic push(input logic [31:0] a, input logic we, input logic [31:0] d);
    e_addr[e_n] = a; e_we[e_n] = we; e_wd[e_n] = d; e_n++;
  endtask

  task automatic model(input logic [31:0] va, input logic wr, input logic usr);
    logic [31:0] da, ta, pde, pte, leaf, la;
    e_n = 0; e_fault = 0; e_code = 0; e_big = 0; e_u = 0; e_w = 0; e_phys = 0;
    da = dir_a(cfg_root, va, cfg_a20_mask);
    pde = rd(da);
    push(da, 0, 0);
    leaf = 0; la = 0;
    if (!pde[0]) begin
      e_fault = 1; e_code = {1'b0, usr, wr, 1'b0};
    end else if (pde[7] && cfg_pse) begin
      e_big = 1;
      if (pde[21]) begin
        e_fault = 1; e_code = {1'b1, usr, wr, 1'b1};
      end else begin
        leaf = pde; la = da; e_u = pde[2]; e_w = pde[1];
        e_phys = {pde[20:13], pde[31:22], va[21:0]};
      end
    end else begin
      if (!pde[5]) begin
        push(da, 1, pde | 32'h20);
        pde = pde | 32'h20;
      end
      ta = tbl_a(pde, va, cfg_a20_mask);
      pte = (ta == da) ? pde : rd(ta);
      push(ta, 0, 0);
      if (!pte[0]) begin
        e_fault = 1; e_code = {1'b0, usr, wr, 1'b0};
      end else begin
        leaf = pte; la = ta; e_u = pde[2] & pte[2]; e_w = pde[1] & pte[1];
        e_phys = {8'h00, pte[31:12], va[11:0]};
      end
    end
    if (!e_fault && (!leaf[5] || (wr && !leaf[6])))
      push(la, 1, leaf | 32'h20 | (wr ? 32'h40 : 32'h0));
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input string tag);
    int t;
    model(va, wr, usr);
    @(negedge clk);
    lg_n = 0;
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10"}, "busy after accept", busy, 1);
    t = 0;
    while (!result_valid && t < 60) begin
      @(negedge clk);
      t++;
    end
    chk({tag, " R10"}, "result arrived", result_valid, 1);
    chk({tag, " R6"}, "fault", fault, e_fault);
    if (e_fault) chk({tag, " R5 R6"}, "fault_code", fault_code, e_code);
    else begin
      chk({tag, " R4"}, "phys_addr", phys_addr, e_phys);
      chk({tag, " R3"}, "big_page", big_page, e_big);
      chk({tag, " R8"}, "rights", {rights_user, rights_write}, {e_u, e_w});
    end
    chk({tag, " R7 R9"}, "op count", lg_n, e_n);
    for (int i = 0; i < e_n && i < lg_n; i++) begin
      chk({tag, " R1 R2 R7 R9"}, "op addr", lg_addr[i], e_addr[i]);
      chk({tag, " R7 R9"}, "op dir", lg_we[i], e_we[i]);
      if (e_we[i]) chk({tag, " R9"}, "op data", lg_wd[i], e_wd[i]);
    end
    @(negedge clk);
    chk({tag, " R10"}, "pulse ends", result_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] va, da, ta;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset mem_req", mem_req, 0);
    chk("R10", "reset result_valid", result_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_root = 32'h0010_0ABC; cfg_pse = 0; cfg_a20_mask = 32'hFFFF_FFFF;
    // R7 R9 R2: 4 KB, both accessed clear, write
    va = 32'h1234_5678;
    da = dir_a(cfg_root, va, cfg_a20_mask);
    mem[da] = 32'h0020_0007;
    ta = tbl_a(32'h0020_0007, va, cfg_a20_mask);
    mem[ta] = 32'hABCD_E007;
    walk(va, 1, 1, "R7 4k-wb");
    chk("R7", "dir accessed set", mem[da], 32'h0020_0027);
    chk("R9", "leaf A and D set", mem[ta], 32'hABCD_E067);
    // R9: accessed and dirty set, read: no write
    walk(va, 0, 0, "R9 no-wb");
    // R9: A set, D clear, read: no write
    mem[ta] = 32'hABCD_E027;
    walk(va, 0, 0, "R9 clean-read");
    // R8: directory lacks write right
    mem[da] = 32'h0020_0025;
    walk(va, 0, 0, "R8 and");
    // R5: 4 KB with bit 21 and 7 set in pte: no reserved fault
    mem[ta] = 32'h0060_00A7;
    walk(va, 1, 0, "R5 small-no-rsvd");
    // R3: PS bit with pse off continues to table
    mem[da] = 32'h0020_00A7;
    walk(va, 0, 1, "R3 pse-off");
    // R3 R4: large page with extended bits
    cfg_pse = 1;
    mem[da] = 32'hC01F_E087;
    walk(va, 1, 1, "R4 4m");
    chk("R4", "high phys bits", phys_addr[39:32], 8'hFF);
    // R5: large page bit 21 reserved
    mem[da] = 32'hC020_00A7;
    walk(va, 1, 1, "R5 rsvd");
    // R6: non-present directory
    mem[da] = 32'h0000_0006;
    walk(va, 1, 0, "R6 np-dir");
    // R6: non-present table entry
    mem[da] = 32'h0020_0027;
    mem[ta] = 32'hFFFF_FFFE;
    walk(va, 0, 1, "R6 np-tbl");
    // R1: mask clears address bit 20 of the root
    cfg_a20_mask = 32'hFFEF_FFFF;
    walk(va, 0, 0, "R1 a20");

    for (int k = 0; k < 400; k++) begin
      cfg_root = $urandom;
      cfg_pse = $urandom_range(0, 1);
      cfg_a20_mask = ($urandom_range(0, 3) == 0) ? 32'hFFEF_FFFF : 32'hFFFF_FFFF;
      walk($urandom, $urandom_range(0, 1), $urandom_range(0, 1), "rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule